// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block sits beside one processor's load/store path and turns a load-linked and store-conditional pair into an atomic read-modify-write. A load-linked is issued to memory as an ordinary read. It also arms a single reservation that holds the cache line of the accessed address. A later store-conditional is written to memory only if that reservation is still armed and covers the same line. The block reports success or failure in the same cycle, and software loops back to the load-linked whenever it sees a failure.

The reservation lasts only while nothing could have disturbed the line. It is dropped in any of these cases: a snoop invalidation of the reserved line, an eviction of that line, a context switch, an ordinary store by this processor to that line, or any store-conditional, whether it succeeds or not. Requests are single-cycle. The memory read and write strobes are combinational from the request, and the reservation state updates on the clock edge.

Top module: `resv_monitor`

## Requirements
- R1: Request op codes are 2'b00 load, 2'b01 store, 2'b10 load-linked and 2'b11 store-conditional. A valid load or load-linked drives `mem_re_o` high in the same cycle, with `mem_we_o` low and `mem_addr_o` equal to the request address.
- R2: A store-conditional succeeds when the reservation is armed and its address falls in the reserved line. In that cycle `sc_ok_o` is 1 and `mem_we_o` is 1, carrying the request address and data. Lines are 16 bytes, so address bits [3:0] are ignored in the compare.
- R3: A store-conditional to a line other than the reserved one fails. `sc_ok_o` is 0 and `mem_we_o` is 0.
- R4: Every store-conditional disarms the reservation, whether it succeeds or fails, so an immediately following store-conditional fails.
- R5: A snoop invalidation whose line equals the reserved line disarms the reservation. A snoop invalidation to any other line leaves it armed.
- R6: An eviction of the reserved line disarms the reservation. An eviction of any other line leaves it armed.
- R7: A context-switch pulse disarms the reservation. This includes a pulse in the same cycle as a load-linked.
- R8: An ordinary store is always written to memory with its address and data. If it targets the reserved line, it also disarms the reservation.
- R9: A snoop invalidation of the line that a store-conditional targets, in the same cycle, makes that store-conditional fail with no write.
- R10: A new load-linked replaces the reservation with its own line. After it, only that line can succeed.
- R11: After reset the reservation is disarmed, so a store-conditional before any load-linked fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_op_i | input | 2 | Request op code (see R1) |
| req_addr_i | input | AW | Request byte address |
| req_wdata_i | input | DW | Store data |
| snoop_inv_i | input | 1 | Snoop invalidation strobe |
| snoop_line_i | input | AW-4 | Line address of the snoop invalidation |
| evict_i | input | 1 | Eviction strobe |
| evict_line_i | input | AW-4 | Line address being evicted |
| ctx_switch_i | input | 1 | Context-switch pulse |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| sc_ok_o | output | 1 | Store-conditional result, meaningful only with a store-conditional request |

## Verification
The assertions assume that a context-switch pulse is the only event that can be seen a cycle later regardless of address. They also assume the request op is one of the four codes whenever the request is valid; the 2-bit field makes that hold for every input. The stimulus draws every address from four lines with random low bits, so matches, near-misses inside a line and snoop or eviction hits all occur often. Invalidations, evictions and context switches arrive at independent random rates, and directed steps place them in the same cycle as a load-linked or store-conditional.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } op_e;
endpackage

// File: rtl/resv_line_cmp.sv
module resv_line_cmp #(
  parameter int LW = 28
) (
  input  logic          en_i,
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  output logic          hit_o
);
  assign hit_o = en_i && (a_i == b_i);
endmodule

// File: rtl/resv_state.sv
module resv_state #(
  parameter int LW = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          keep_i,
  input  logic [LW-1:0] line_i,
  input  logic          clr_i,
  output logic          armed_o,
  output logic [LW-1:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      line_o  <= '0;
    end else if (load_i) begin
      armed_o <= keep_i;
      line_o  <= line_i;
    end else if (clr_i) begin
      armed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 16,
  localparam int OFFS      = $clog2(LINE_BYTES),
  localparam int LW        = AW - OFFS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          snoop_inv_i,
  input  logic [LW-1:0] snoop_line_i,
  input  logic          evict_i,
  input  logic [LW-1:0] evict_line_i,
  input  logic          ctx_switch_i,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          sc_ok_o
);
  localparam int NSRC = 2;

  logic          is_ld, is_st, is_ll, is_sc;
  logic [LW-1:0] req_line, resv_line;
  logic          armed, same_line;
  logic          kill_cur, kill_new, pass, clr;
  logic [NSRC-1:0]         src_en;
  logic [NSRC-1:0][LW-1:0] src_line;
  logic [NSRC-1:0]         hit_resv, hit_req;

  assign is_ld    = req_valid_i && (req_op_i == OP_LOAD);
  assign is_st    = req_valid_i && (req_op_i == OP_STORE);
  assign is_ll    = req_valid_i && (req_op_i == OP_LINK);
  assign is_sc    = req_valid_i && (req_op_i == OP_COND);
  assign req_line = req_addr_i[AW-1:OFFS];

  assign src_en   = {evict_i, snoop_inv_i};
  assign src_line = {evict_line_i, snoop_line_i};

  // each external kill source checked against the held and the incoming line
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    resv_line_cmp #(.LW(LW)) u_vs_resv (
      .en_i(src_en[g]), .a_i(src_line[g]), .b_i(resv_line), .hit_o(hit_resv[g]));
    resv_line_cmp #(.LW(LW)) u_vs_req (
      .en_i(src_en[g]), .a_i(src_line[g]), .b_i(req_line), .hit_o(hit_req[g]));
  end

  resv_line_cmp #(.LW(LW)) u_same (
    .en_i(armed), .a_i(req_line), .b_i(resv_line), .hit_o(same_line));

  assign kill_cur = ctx_switch_i || (|hit_resv);
  assign kill_new = ctx_switch_i || (|hit_req);
  // a same-cycle kill of the reserved line beats the store-conditional
  assign pass     = is_sc && same_line && !kill_cur;
  assign clr      = is_sc || (is_st && same_line) || kill_cur;

  resv_state #(.LW(LW)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (is_ll),
    .keep_i  (!kill_new),
    .line_i  (req_line),
    .clr_i   (clr),
    .armed_o (armed),
    .line_o  (resv_line)
  );

  assign mem_re_o    = is_ld || is_ll;
  assign mem_we_o    = is_st || pass;
  assign mem_addr_o  = req_addr_i;
  assign mem_wdata_o = req_wdata_i;
  assign sc_ok_o     = pass;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int AW   = 32,
  parameter int OFFS = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    req_op_i,
  input logic [AW-1:0] req_addr_i,
  input logic          snoop_inv_i,
  input logic [AW-OFFS-1:0] snoop_line_i,
  input logic          ctx_switch_i,
  input logic          mem_re_o,
  input logic          mem_we_o,
  input logic          sc_ok_o
);
  logic req_sc;
  assign req_sc = req_valid_i && (req_op_i == 2'b11);

  AST_READ_NOT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o)); // R1
  AST_OK_NEEDS_SC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_ok_o |-> (req_sc && mem_we_o)); // R2
  AST_SC_THEN_SC_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_sc |=> !sc_ok_o); // R4
  AST_CTX_KILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_switch_i |=> !sc_ok_o); // R7
  AST_SNOOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_sc && snoop_inv_i && snoop_line_i == req_addr_i[AW-1:OFFS]) |-> !sc_ok_o); // R9
endmodule

bind resv_monitor resv_monitor_chk #(.AW(AW), .OFFS(OFFS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
  .req_addr_i(req_addr_i), .snoop_inv_i(snoop_inv_i), .snoop_line_i(snoop_line_i),
  .ctx_switch_i(ctx_switch_i), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
  .sc_ok_o(sc_ok_o));

// File: tb/sim_resv_monitor.sv
`timescale 1ns/1ps
module sim_resv_monitor;
  localparam int AW = 32, DW = 32, LW = 28;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0; logic [1:0] req_op_i = 0;
  logic [AW-1:0] req_addr_i = 0; logic [DW-1:0] req_wdata_i = 0;
  logic snoop_inv_i = 0; logic [LW-1:0] snoop_line_i = 0;
  logic evict_i = 0; logic [LW-1:0] evict_line_i = 0;
  logic ctx_switch_i = 0;
  logic mem_re_o, mem_we_o, sc_ok_o;
  logic [AW-1:0] mem_addr_o; logic [DW-1:0] mem_wdata_o;

  int checks = 0, errors = 0;
  bit ref_armed = 0; logic [LW-1:0] ref_line = 0;

  always #4 clk_i = ~clk_i;

  resv_monitor u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] ln(input logic [AW-1:0] a);
    return a[AW-1:4];
  endfunction

  // one request cycle: drive at negedge, compare mid-cycle, update model at posedge
  task automatic step(input bit v, input logic [1:0] op, input logic [AW-1:0] a,
                      input bit snp, input logic [LW-1:0] sl, input bit ev,
                      input logic [LW-1:0] el, input bit cs, input string tag);
    bit kill_cur, kill_new, e_ok, e_we, e_re;
    logic [DW-1:0] d;
    d = $urandom;
    req_valid_i = v; req_op_i = op; req_addr_i = a; req_wdata_i = d;
    snoop_inv_i = snp; snoop_line_i = sl; evict_i = ev; evict_line_i = el;
    ctx_switch_i = cs;
    #2;
    kill_cur = cs || (snp && sl == ref_line) || (ev && el == ref_line);
    kill_new = cs || (snp && sl == ln(a)) || (ev && el == ln(a));
    e_ok = v && op == SC && ref_armed && ln(a) == ref_line && !kill_cur;
    e_we = (v && op == ST) || e_ok;
    e_re = v && (op == LD || op == LL);
    chk(sc_ok_o == e_ok, tag, sc_ok_o, e_ok);
    chk(mem_we_o == e_we, tag, mem_we_o, e_we);
    chk(mem_re_o == e_re, "R1", mem_re_o, e_re);
    if (e_we || e_re) chk(mem_addr_o == a, "R1", mem_addr_o, a);
    if (e_we) chk(mem_wdata_o == d, "R8", mem_wdata_o, d);
    @(posedge clk_i);
    if (v && op == LL) begin ref_armed = !kill_new; ref_line = ln(a); end
    else if ((v && op == SC) || (v && op == ST && ln(a) == ref_line) || kill_cur) ref_armed = 0;
    @(negedge clk_i);
  endtask

  task automatic rq(input logic [1:0] op, input logic [AW-1:0] a, input string tag);
    step(1, op, a, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    chk(mem_re_o == 0 && mem_we_o == 0, "R11", {mem_re_o, mem_we_o}, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    rq(SC, 32'h100, "R11");                       // no reservation after reset
    rq(LL, 32'h104, "R1");
    rq(SC, 32'h10c, "R2");                        // same line, other offset
    rq(SC, 32'h10c, "R4");                        // already consumed
    rq(LL, 32'h200, "R1"); rq(SC, 32'h210, "R3"); rq(SC, 32'h200, "R4");
    rq(LL, 32'h300, "R1");
    step(1, LD, 32'h0, 1, 28'h31, 0, 0, 0, "R5"); // other-line snoop keeps it
    rq(SC, 32'h300, "R5");
    rq(LL, 32'h300, "R1");
    step(0, LD, 0, 1, 28'h30, 0, 0, 0, "R5"); rq(SC, 32'h300, "R5");
    rq(LL, 32'h400, "R1");
    step(0, LD, 0, 0, 0, 1, 28'h41, 0, "R6"); rq(SC, 32'h400, "R6");
    rq(LL, 32'h400, "R1");
    step(0, LD, 0, 0, 0, 1, 28'h40, 0, "R6"); rq(SC, 32'h400, "R6");
    rq(LL, 32'h500, "R1");
    step(0, LD, 0, 0, 0, 0, 0, 1, "R7"); rq(SC, 32'h500, "R7");
    step(1, LL, 32'h500, 0, 0, 0, 0, 1, "R7"); rq(SC, 32'h500, "R7");
    rq(LL, 32'h600, "R1"); rq(ST, 32'h700, "R8"); rq(SC, 32'h600, "R8");
    rq(LL, 32'h600, "R1"); rq(ST, 32'h608, "R8"); rq(SC, 32'h600, "R8");
    rq(LL, 32'h800, "R1");
    step(1, SC, 32'h800, 1, 28'h80, 0, 0, 0, "R9");
    rq(LL, 32'h900, "R1"); rq(LL, 32'ha00, "R10");
    rq(SC, 32'h900, "R10");
    rq(LL, 32'h900, "R1"); rq(LL, 32'ha00, "R10"); rq(SC, 32'ha04, "R10");
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] op; logic [AW-1:0] a; logic [LW-1:0] sl, el;
      op = 2'($urandom);
      a  = {26'h0, 2'($urandom), 4'($urandom)};
      sl = {26'h0, 2'($urandom)};
      el = {26'h0, 2'($urandom)};
      step($urandom_range(0, 7) != 0, op, a, $urandom_range(0, 7) == 0, sl,
           $urandom_range(0, 15) == 0, el, $urandom_range(0, 31) == 0, "R2");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule